// File: doc/BRIEF.md
# Parallel Flash Command Front-End

This block stands in for a byte-wide parallel NOR flash part during memory controller bring-up. It watches the asynchronous bus strobes (chip enable, write enable, output enable) with the core clock and turns each completed write pulse into one write event. A strict checker follows the events through the protection unlock sequence. Only a complete program or erase sequence changes the small on-chip byte store.

After a sequence completes, an internal busy timer runs for a number of clock cycles set by a parameter for each operation. While it runs, a bus read returns a status byte instead of array data. Bit 7 is the data-poll bit and bit 6 flips on every finished read. A controller can therefore run its usual polling loops against the block. Erase sets bytes to 0xFF. Program can only clear bits.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset no operation is busy and every byte of the store reads 0xFF.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, followed by a fourth write of data D to address A, program byte A (low address bits) to old AND D once PGM_CYC cycles have passed.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555 and 0x55@0x2AAA are followed by a sixth write. If that sixth write is 0x30 to address A, it erases the SECT_BYTES-aligned sector holding A. If it is 0x50 to address A, it erases the BLK_BYTES-aligned block holding A. If it is 0x10 to 0x5555, it erases the whole store. An erase sets the affected bytes to 0xFF and leaves all other bytes unchanged.
- R4: A write that does not match the next expected step drops the sequence back to idle, so the writes that follow the unlock steps do not modify the store.
- R5: A write pulse is ignored when output enable is low or inhibit_i is high during it. An ignored pulse neither advances nor aborts a sequence.
- R6: While a program is busy, read bit 7 is the complement of bit 7 of the value being stored.
- R7: While an erase is busy, read bit 7 is 0. After the erase, the erased bytes read 0xFF.
- R8: While busy, bit 6 of consecutive reads alternates. When idle, consecutive reads of the same byte return the same bit 6.
- R9: Status reads begin directly after the write that completes a sequence. Write pulses during busy are ignored.
- R10: For SETTLE_CYC cycles after a program ends, reads of the programmed byte return the final bit 7 with the old bits 6..0. After that window the full final value is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; a write is taken when the pulse ends |
| oe_ni | input | 1 | Output enable, active low |
| inhibit_i | input | 1 | Supply-low write inhibit |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or status byte |

## Verification
The bench goes after broken sequences and strobe qualification. A checker that resets on a mismatch too late, or that counts an inhibited pulse as a step, would program a byte that must stay 0xFF. It also pairs an already-programmed byte with a second program. A store that overwrote instead of ANDing would read the new data rather than the intersection. Erase tests place untouched bytes just outside the sector and block boundaries, where an off-by-one range decode shows up as a wrongly erased byte. The polling tests catch a flipped data-poll polarity and a toggle bit that stops too early or keeps moving when idle. They also catch a settle window that exposes the new low bits too soon.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_PGM, OP_SEC, OP_BLK, OP_CHIP} op_e;

  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] KEY_ADDR_A = 16'h5555;
  localparam logic [AW-1:0] KEY_ADDR_B = 16'h2AAA;
  localparam logic [7:0] KEY_A    = 8'hAA;
  localparam logic [7:0] KEY_B    = 8'h55;
  localparam logic [7:0] CMD_PGM  = 8'hA0;
  localparam logic [7:0] CMD_ERS  = 8'h80;
  localparam logic [7:0] CMD_SEC  = 8'h30;
  localparam logic [7:0] CMD_BLK  = 8'h50;
  localparam logic [7:0] CMD_CHIP = 8'h10;
endpackage

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
  import flash_cmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_evt_i,
  input  logic          lock_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          start_o,
  output op_e           op_o
);
  typedef enum logic [2:0] {S_IDLE, S_K1, S_K2, S_PGM, S_E1, S_E2, S_E3} st_e;
  st_e st_q, st_d;

  logic key1, key2;
  assign key1 = (addr_i == KEY_ADDR_A) && (data_i == KEY_A);
  assign key2 = (addr_i == KEY_ADDR_B) && (data_i == KEY_B);

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    op_o    = OP_NONE;
    if (wr_evt_i && !lock_i) begin
      unique case (st_q)
        S_IDLE: st_d = key1 ? S_K1 : S_IDLE;
        S_K1:   st_d = key2 ? S_K2 : S_IDLE;
        S_K2: begin
          st_d = S_IDLE;
          if (addr_i == KEY_ADDR_A && data_i == CMD_PGM) st_d = S_PGM;
          if (addr_i == KEY_ADDR_A && data_i == CMD_ERS) st_d = S_E1;
        end
        S_PGM: begin
          st_d    = S_IDLE;
          start_o = 1'b1;
          op_o    = OP_PGM;
        end
        S_E1: st_d = key1 ? S_E2 : S_IDLE;
        S_E2: st_d = key2 ? S_E3 : S_IDLE;
        S_E3: begin
          st_d = S_IDLE;
          if (data_i == CMD_SEC) begin
            start_o = 1'b1;
            op_o    = OP_SEC;
          end else if (data_i == CMD_BLK) begin
            start_o = 1'b1;
            op_o    = OP_BLK;
          end else if (data_i == CMD_CHIP && addr_i == KEY_ADDR_A) begin
            start_o = 1'b1;
            op_o    = OP_CHIP;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_cmd_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned PGM_CYC  = 20,
  parameter int unsigned SEC_CYC  = 40,
  parameter int unsigned BLK_CYC  = 60,
  parameter int unsigned CHIP_CYC = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  op_e              op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             busy_o,
  output logic             done_o,
  output op_e              op_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       data_o
);
  localparam int unsigned MAX_A = (PGM_CYC > SEC_CYC) ? PGM_CYC : SEC_CYC;
  localparam int unsigned MAX_B = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt_q, load;

  always_comb begin
    unique case (op_i)
      OP_SEC:  load = CW'(SEC_CYC - 1);
      OP_BLK:  load = CW'(BLK_CYC - 1);
      OP_CHIP: load = CW'(CHIP_CYC - 1);
      default: load = CW'(PGM_CYC - 1);
    endcase
  end

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      op_o   <= OP_NONE;
      idx_o  <= '0;
      data_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= load;
      op_o   <= op_i;
      idx_o  <= idx_i;
      data_o <= data_i;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_byte_store.sv
module flash_byte_store
  import flash_cmd_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned SECT_BYTES = 4,
  parameter int unsigned BLK_BYTES  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     done_i,
  input  op_e                      op_i,
  input  logic [$clog2(DEPTH)-1:0] tgt_i,
  input  logic [7:0]               data_i,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
  output logic [7:0]               rd_byte_o,
  output logic [7:0]               tgt_byte_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned SEC_W = $clog2(SECT_BYTES);
  localparam int unsigned BLK_W = $clog2(BLK_BYTES);

  logic [7:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic sec_hit, blk_hit, ers_hit;
    assign sec_hit = (MY_IDX >> SEC_W) == (tgt_i >> SEC_W);
    assign blk_hit = (MY_IDX >> BLK_W) == (tgt_i >> BLK_W);
    assign ers_hit = (op_i == OP_CHIP) || (op_i == OP_SEC && sec_hit) ||
                     (op_i == OP_BLK && blk_hit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= 8'hFF;
      else if (done_i) begin
        if (op_i == OP_PGM && MY_IDX == tgt_i) mem_q[i] <= mem_q[i] & data_i;
        else if (ers_hit)                       mem_q[i] <= 8'hFF;
      end
    end
  end

  assign rd_byte_o  = mem_q[rd_idx_i];
  assign tgt_byte_o = mem_q[tgt_i];
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_cmd_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned SECT_BYTES = 4,
  parameter int unsigned BLK_BYTES  = 8,
  parameter int unsigned PGM_CYC    = 20,
  parameter int unsigned SEC_CYC    = 40,
  parameter int unsigned BLK_CYC    = 60,
  parameter int unsigned CHIP_CYC   = 80,
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          inhibit_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    data_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned STL_W = $clog2(SETTLE_CYC + 1);

  logic          wr_act, rd_act, wr_q, rd_q, wr_evt, rd_end;
  logic [AW-1:0] waddr_q;
  logic [7:0]    wdata_q;
  logic          start, busy, done, tog_q;
  op_e           op_new, op_act;
  logic [IDX_W-1:0] tgt_idx, rd_idx;
  logic [7:0]    tgt_data, rd_byte, tgt_byte, pgm_res, stl_old_q;
  logic [STL_W-1:0] stl_cnt_q;

  assign wr_act = !ce_ni && !we_ni && oe_ni && !inhibit_i;
  assign rd_act = !ce_ni && !oe_ni && we_ni;
  assign wr_evt = wr_q && !wr_act;  // pulse end
  assign rd_end = rd_q && !rd_act;
  assign rd_idx = addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act) begin
        waddr_q <= addr_i;
        wdata_q <= data_i;
      end
    end
  end

  flash_unlock_seq u_seq (
    .clk_i, .rst_ni,
    .wr_evt_i (wr_evt),
    .lock_i   (busy),
    .addr_i   (waddr_q),
    .data_i   (wdata_q),
    .start_o  (start),
    .op_o     (op_new)
  );

  flash_busy_timer #(
    .IDX_W(IDX_W), .PGM_CYC(PGM_CYC), .SEC_CYC(SEC_CYC),
    .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk_i, .rst_ni,
    .start_i (start),
    .op_i    (op_new),
    .idx_i   (waddr_q[IDX_W-1:0]),
    .data_i  (wdata_q),
    .busy_o  (busy),
    .done_o  (done),
    .op_o    (op_act),
    .idx_o   (tgt_idx),
    .data_o  (tgt_data)
  );

  flash_byte_store #(
    .DEPTH(DEPTH), .SECT_BYTES(SECT_BYTES), .BLK_BYTES(BLK_BYTES)
  ) u_store (
    .clk_i, .rst_ni,
    .done_i     (done),
    .op_i       (op_act),
    .tgt_i      (tgt_idx),
    .data_i     (tgt_data),
    .rd_idx_i   (rd_idx),
    .rd_byte_o  (rd_byte),
    .tgt_byte_o (tgt_byte)
  );

  assign pgm_res = tgt_byte & tgt_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q     <= 1'b0;
      stl_cnt_q <= '0;
      stl_old_q <= '0;
    end else begin
      if (start)              tog_q <= 1'b0;
      else if (busy && rd_end) tog_q <= ~tog_q;
      if (done && op_act == OP_PGM) begin
        stl_cnt_q <= STL_W'(SETTLE_CYC);
        stl_old_q <= tgt_byte;
      end else if (stl_cnt_q != '0) begin
        stl_cnt_q <= stl_cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (busy) begin
      if (op_act == OP_PGM) data_o = {~pgm_res[7], tog_q, rd_byte[5:0]};
      else                  data_o = {1'b0, tog_q, rd_byte[5:0]};
    end else if (stl_cnt_q != '0 && rd_idx == tgt_idx) begin
      data_o = {rd_byte[7], stl_old_q[6:0]};
    end else begin
      data_o = rd_byte;
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_evt,
  input logic       start,
  input logic       busy,
  input logic       done,
  input op_e        op_act,
  input logic       rd_act,
  input logic       tog_q,
  input logic [7:0] data_o
);
  // R9
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_evt));

  // R9
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy);

  // R4
  start_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (wr_evt && !busy));

  // R7
  erase_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op_act != OP_PGM && rd_act) |-> !data_o[7]);

  // R8
  idle_tog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(!busy) && !start) |-> $stable(tog_q));
endmodule

bind flash_cmd_frontend flash_cmd_chk chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_evt (wr_evt),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .op_act (op_act),
  .rd_act (rd_act),
  .tog_q  (tog_q),
  .data_o (data_o)
);

// File: tb/flash_cmd_frontend_tb_top.sv
module flash_cmd_frontend_tb_top;
  localparam int unsigned PGM_CYC    = 20;
  localparam int unsigned SEC_CYC    = 40;
  localparam int unsigned BLK_CYC    = 60;
  localparam int unsigned CHIP_CYC   = 80;
  localparam int unsigned SETTLE_CYC = 8;
  localparam int unsigned NVEC       = 4;
  // {idx, data, expected}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd2,  8'hA5, 8'hA5},
    {4'd2,  8'h3C, 8'h24},
    {4'd9,  8'h0F, 8'h0F},
    {4'd15, 8'h80, 8'h80}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, inh = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0, dout;
  int tests = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  flash_cmd_frontend #(
    .PGM_CYC(PGM_CYC), .SEC_CYC(SEC_CYC), .BLK_CYC(BLK_CYC),
    .CHIP_CYC(CHIP_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .inhibit_i(inh), .addr_i(addr), .data_i(din), .data_o(dout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [15:0] a, input logic [7:0] d, input logic oe_v, input logic inh_v);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_v; inh = inh_v;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; inh = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_raw(a, d, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    q = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pgm(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic ers(input logic [15:0] a, input logic [7:0] code);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(a, code);
  endtask

  task automatic settle();
    repeat (CHIP_CYC + SETTLE_CYC + 8) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q, q2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(16'h0000, q); check(q == 8'hFF, "R1 reset byte 0", q, 8'hFF);
    rd(16'h000F, q); check(q == 8'hFF, "R1 reset byte 15", q, 8'hFF);

    for (int i = 0; i < NVEC; i++) begin
      pgm({12'h0, VEC[i][19:16]}, VEC[i][15:8]);
      rd({12'h0, VEC[i][19:16]}, q);
      check(q[7] == ~VEC[i][7], "R6 R9 program poll bit7", {7'h0, q[7]}, {7'h0, ~VEC[i][7]});
      settle();
      rd({12'h0, VEC[i][19:16]}, q);
      check(q == VEC[i][7:0], "R2 programmed value", q, VEC[i][7:0]);
    end

    // R8 toggle while busy, steady when idle
    pgm(16'h0005, 8'h00);
    rd(16'h0005, q); rd(16'h0005, q2);
    check(q[6] != q2[6], "R8 busy toggle", {7'h0, q2[6]}, {7'h0, ~q[6]});
    settle();
    rd(16'h0005, q); rd(16'h0005, q2);
    check(q == q2, "R8 idle steady", q2, q);

    // R10 settle window: FF programmed with 12
    pgm(16'h0000, 8'h12);
    q = 8'hFF;
    for (int k = 0; k < 40 && q[7]; k++) rd(16'h0000, q);
    check(q == 8'h7F, "R10 settle bit7 new, low old", q, 8'h7F);
    repeat (SETTLE_CYC + 4) @(negedge clk);
    rd(16'h0000, q); check(q == 8'h12, "R10 after settle", q, 8'h12);

    // R4 abort: bad second step
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h00); wr(16'h5555, 8'hA0); wr(16'h0003, 8'h00);
    settle();
    rd(16'h0003, q); check(q == 8'hFF, "R4 aborted sequence", q, 8'hFF);

    // R5 ignored pulses do not advance or abort
    wr(16'h5555, 8'hAA);
    wr_raw(16'h2AAA, 8'h55, 1'b1, 1'b1);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'hA0);
    wr_raw(16'h0004, 8'h00, 1'b0, 1'b0);
    rd(16'h0004, q); check(q == 8'hFF, "R5 oe-low write ignored", q, 8'hFF);
    wr(16'h0004, 8'h0F);
    settle();
    rd(16'h0004, q); check(q == 8'h0F, "R5 sequence kept through ignored pulses", q, 8'h0F);

    // R3 / R7 sector erase of sector 0 (bytes 0..3)
    ers(16'h0001, 8'h30);
    rd(16'h0002, q); check(q[7] == 1'b0, "R7 erase poll bit7", {7'h0, q[7]}, 8'h00);
    settle();
    rd(16'h0002, q); check(q == 8'hFF, "R3 R7 sector erased", q, 8'hFF);
    rd(16'h0000, q); check(q == 8'hFF, "R3 sector erased byte 0", q, 8'hFF);
    rd(16'h0004, q); check(q == 8'h0F, "R3 next sector kept", q, 8'h0F);

    // block erase of block 1 (bytes 8..15)
    ers(16'h000C, 8'h50);
    settle();
    rd(16'h0009, q); check(q == 8'hFF, "R3 block erased byte 9", q, 8'hFF);
    rd(16'h000F, q); check(q == 8'hFF, "R3 block erased byte 15", q, 8'hFF);
    rd(16'h0005, q); check(q == 8'h00, "R3 other block kept", q, 8'h00);

    // chip erase; program attempt during busy is ignored
    ers(16'h5555, 8'h10);
    pgm(16'h0007, 8'h00);
    settle();
    rd(16'h0005, q); check(q == 8'hFF, "R3 chip erased", q, 8'hFF);
    rd(16'h0007, q); check(q == 8'hFF, "R9 write during busy ignored", q, 8'hFF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule